// File: doc/BRIEF.md
# Dual-Phase Multiplexed-Address Read Sequencer

This block times one asynchronous read from an external device whose address and data share one bus. The full address is twice as wide as the bus, so it goes out in two halves: the upper half first, then the lower half. The output-enable strobe has two jobs. During the address phases its level tells the device which half is on the bus: low for the upper half and high for the lower half. Its second low pulse is the actual read strobe. The address-valid strobe also pulses twice, once for each half.

A single tick counter runs from 0 after an accepted start pulse up to a programmable end tick. Every strobe edge is a programmable tick on that counter. The strobes are combinational decodes of the counter window. All strobes are active low and idle high.

The bus is driven only while the direction flag says "output". That ends at the tick where output-enable asserts for the second time. Read data is captured from the returning bus at a programmable access tick. A one-cycle completion pulse follows the end tick.

The configuration is checked for ordering when a start is requested. A badly ordered set of ticks raises an error flag, and no access is started. The tick inputs must be held stable while an access runs.

Top module: `mux2_read_seq`

## Requirements
- R1: After reset, cs_n, adv_n and oe_n are 1, bus_oe, dir, busy, done and cfg_err are 0, and rdata is 0.
- R2: With tick k counted from 0 in the first cycle after the accepting edge, the bus drives the upper address half (addr[2*BUS_W-1:BUS_W]) for k < oe1_off. It drives the lower half for oe1_off <= k < oe2_on. In both of these ranges bus_oe and dir are 1. From tick oe2_on onward, bus_oe and dir are 0.
- R3: adv_n is 0 exactly at ticks in [adv1_on, adv1_off) or in [adv2_on, adv2_off).
- R4: oe_n is 0 exactly at ticks in [oe1_on, oe1_off) or in [oe2_on, oe2_off).
- R5: cs_n is 0 exactly at ticks in [cs_on, cs_off).
- R6: rdata takes the value of bus_in at the clock edge that ends tick acc_tick. It holds that value until a later access captures new data.
- R7: done is 1 for exactly one cycle: the cycle after tick end_tick. busy is 0 in that cycle.
- R8: A start pulse that arrives while busy is 1 is ignored. The running access keeps its address and timing, and only one done pulse results.
- R9: A start pulse is rejected and cfg_err is set if any of these orderings fails: adv1_on<adv1_off<adv2_on<adv2_off, oe1_on<oe1_off<oe2_on<oe2_off, cs_on<cs_off, or oe2_on<=acc_tick<oe2_off. It is also rejected if adv2_off, oe2_off, cs_off or acc_tick exceeds end_tick. A rejected start leaves the block idle with no done pulse. The next accepted start clears cfg_err.
- R10: Whenever busy is 0, all strobes are 1 and bus_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| addr | input | 2*BUS_W | Full address, latched at start |
| cs_on | input | M_W | Chip-select assert tick |
| cs_off | input | CNT_W | Chip-select deassert tick |
| adv1_on | input | S_W | Address-valid first assert tick |
| adv1_off | input | S_W | Address-valid first deassert tick |
| adv2_on | input | M_W | Address-valid second assert tick |
| adv2_off | input | CNT_W | Address-valid second deassert tick |
| oe1_on | input | S_W | Output-enable first assert tick |
| oe1_off | input | S_W | Output-enable first deassert tick (end of upper phase) |
| oe2_on | input | M_W | Output-enable second assert tick (bus turnaround) |
| oe2_off | input | CNT_W | Output-enable second deassert tick |
| acc_tick | input | CNT_W | Read data capture tick |
| end_tick | input | CNT_W | Last tick of the access |
| bus_in | input | BUS_W | Bus value returned by the device |
| bus_out | output | BUS_W | Bus value driven by the block |
| bus_oe | output | 1 | Bus driver enable |
| dir | output | 1 | Direction, 1 = output to device |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| rdata | output | BUS_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| cfg_err | output | 1 | Last start rejected for tick ordering |

## Verification
The bench uses the default widths: a 16-bit bus with a 32-bit address, 3-bit and 4-bit short tick fields, and a 5-bit counter. These widths let it program the tightest legal timing, with each phase one tick long and capture at the turnaround tick. They also let it program the widest timing, where the read strobe runs to tick 31 and the counter ends at its top value without wrapping. Each tick of every access is compared against windows that the bench computes itself. A modelled device returns data only while the read strobe is low and the bus is released, so capture timing is checked directly.

// File: rtl/mux2_read_seq.sv
module mux2_read_seq #(
  parameter int BUS_W = 16,
  parameter int CNT_W = 5,
  parameter int S_W   = 3,
  parameter int M_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2*BUS_W-1:0] addr,
  input  logic [M_W-1:0]     cs_on,
  input  logic [CNT_W-1:0]   cs_off,
  input  logic [S_W-1:0]     adv1_on,
  input  logic [S_W-1:0]     adv1_off,
  input  logic [M_W-1:0]     adv2_on,
  input  logic [CNT_W-1:0]   adv2_off,
  input  logic [S_W-1:0]     oe1_on,
  input  logic [S_W-1:0]     oe1_off,
  input  logic [M_W-1:0]     oe2_on,
  input  logic [CNT_W-1:0]   oe2_off,
  input  logic [CNT_W-1:0]   acc_tick,
  input  logic [CNT_W-1:0]   end_tick,
  input  logic [BUS_W-1:0]   bus_in,
  output logic [BUS_W-1:0]   bus_out,
  output logic               bus_oe,
  output logic               dir,
  output logic               cs_n,
  output logic               adv_n,
  output logic               oe_n,
  output logic [BUS_W-1:0]   rdata,
  output logic               done,
  output logic               busy,
  output logic               cfg_err
);
  localparam int ADDR_W = 2 * BUS_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              busy_q, done_q, err_q;
  logic [BUS_W-1:0]  rdata_q;

  wire [CNT_W-1:0] t_cs_on  = CNT_W'(cs_on);
  wire [CNT_W-1:0] t_a1_on  = CNT_W'(adv1_on);
  wire [CNT_W-1:0] t_a1_off = CNT_W'(adv1_off);
  wire [CNT_W-1:0] t_a2_on  = CNT_W'(adv2_on);
  wire [CNT_W-1:0] t_o1_on  = CNT_W'(oe1_on);
  wire [CNT_W-1:0] t_o1_off = CNT_W'(oe1_off);
  wire [CNT_W-1:0] t_o2_on  = CNT_W'(oe2_on);

  wire cfg_ok = (t_a1_on < t_a1_off) && (t_a1_off < t_a2_on) && (t_a2_on < adv2_off) &&
                (t_o1_on < t_o1_off) && (t_o1_off < t_o2_on) && (t_o2_on < oe2_off) &&
                (t_cs_on < cs_off) && (t_o2_on <= acc_tick) && (acc_tick < oe2_off) &&
                (adv2_off <= end_tick) && (oe2_off <= end_tick) &&
                (cs_off <= end_tick) && (acc_tick <= end_tick);

  function automatic logic in_win(input logic [CNT_W-1:0] k, lo, hi);
    return (k >= lo) && (k < hi);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (cfg_ok) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            addr_q <= addr;
            err_q  <= 1'b0;
          end else begin
            err_q  <= 1'b1;
          end
        end
      end else begin
        if (cnt_q == acc_tick) rdata_q <= bus_in;
        if (cnt_q == end_tick) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  wire drive = busy_q && (cnt_q < t_o2_on);

  assign dir     = drive;
  assign bus_oe  = drive;
  assign bus_out = !drive ? '0 :
                   (cnt_q < t_o1_off) ? addr_q[ADDR_W-1:BUS_W] : addr_q[BUS_W-1:0];
  assign cs_n    = !(busy_q && in_win(cnt_q, t_cs_on, cs_off));
  assign adv_n   = !(busy_q && (in_win(cnt_q, t_a1_on, t_a1_off) ||
                                in_win(cnt_q, t_a2_on, adv2_off)));
  assign oe_n    = !(busy_q && (in_win(cnt_q, t_o1_on, t_o1_off) ||
                                in_win(cnt_q, t_o2_on, oe2_off)));
  assign rdata   = rdata_q;
  assign done    = done_q;
  assign busy    = busy_q;
  assign cfg_err = err_q;
endmodule

module mux2_read_seq_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             cfg_err,
  input logic             cs_n,
  input logic             adv_n,
  input logic             oe_n,
  input logic             bus_oe,
  input logic [BUS_W-1:0] rdata
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && adv_n && oe_n && !bus_oe));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_err_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  a_r6_rdata_only_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(busy));
endmodule

bind mux2_read_seq mux2_read_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cfg_err(cfg_err),
  .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .bus_oe(bus_oe), .rdata(rdata)
);

// File: tb/test_mux2_read_seq.sv
module test_mux2_read_seq;
  localparam int BUS_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2*BUS_W-1:0] addr = '0;
  logic [3:0] cs_on, adv2_on, oe2_on;
  logic [4:0] cs_off, adv2_off, oe2_off, acc_tick, end_tick;
  logic [2:0] adv1_on, adv1_off, oe1_on, oe1_off;
  logic [BUS_W-1:0] bus_in, bus_out, rdata, dev_data;
  logic bus_oe, dir, cs_n, adv_n, oe_n, done, busy, cfg_err;

  int n_tests = 0, n_fail = 0;
  logic [BUS_W-1:0] exp_q[$];

  always #5 clk = ~clk;

  assign bus_in = (!oe_n && !bus_oe) ? dev_data : 16'hBAD0;

  mux2_read_seq i_mux2_read_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
    .cs_on(cs_on), .cs_off(cs_off), .adv1_on(adv1_on), .adv1_off(adv1_off),
    .adv2_on(adv2_on), .adv2_off(adv2_off), .oe1_on(oe1_on), .oe1_off(oe1_off),
    .oe2_on(oe2_on), .oe2_off(oe2_off), .acc_tick(acc_tick), .end_tick(end_tick),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .dir(dir),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .rdata(rdata), .done(done),
    .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic win(input int k, input int lo, input int hi);
    return (k >= lo) && (k < hi);
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R8 unexpected done", 32'(done), 32'd0);
      else chk("R6 scoreboard rdata", 32'(rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic set_cfg(input int c0, c1, a0, a1, a2, a3, o0, o1, o2, o3, ac, en);
    cs_on = 4'(c0); cs_off = 5'(c1);
    adv1_on = 3'(a0); adv1_off = 3'(a1); adv2_on = 4'(a2); adv2_off = 5'(a3);
    oe1_on = 3'(o0); oe1_off = 3'(o1); oe2_on = 4'(o2); oe2_off = 5'(o3);
    acc_tick = 5'(ac); end_tick = 5'(en);
  endtask

  task automatic run_read(input logic [31:0] a, input logic [15:0] d, input bit poke);
    int en = int'(end_tick);
    exp_q.push_back(d);
    dev_data = d;
    addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 good start clears cfg_err", 32'(cfg_err), 32'd0);
    for (int k = 0; k <= en; k++) begin
      logic drv;
      logic [15:0] eb;
      if (poke && k == 1) begin start = 1'b1; addr = ~a; end
      if (poke && k == 2) start = 1'b0;
      drv = (k < int'(oe2_on));
      eb = !drv ? 16'h0 : (k < int'(oe1_off)) ? a[31:16] : a[15:0];
      chk("R2 bus_oe", 32'(bus_oe), 32'(drv));
      chk("R2 dir", 32'(dir), 32'(drv));
      chk("R2 bus_out", 32'(bus_out), 32'(eb));
      chk("R3 adv_n", 32'(adv_n), 32'(!(win(k, adv1_on, adv1_off) || win(k, adv2_on, adv2_off))));
      chk("R4 oe_n", 32'(oe_n), 32'(!(win(k, oe1_on, oe1_off) || win(k, oe2_on, oe2_off))));
      chk("R5 cs_n", 32'(cs_n), 32'(!win(k, cs_on, cs_off)));
      @(negedge clk);
    end
    chk("R7 done after end tick", 32'(done), 32'd1);
    chk("R7 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R7 done one cycle", 32'(done), 32'd0);
    chk("R10 idle strobes", 32'({cs_n, adv_n, oe_n, bus_oe}), 32'b1110);
    chk("R6 rdata held after access", 32'(rdata), 32'(d));
    if (poke) chk("R8 no second access", 32'(busy), 32'd0);
  endtask

  task automatic main();
    set_cfg(0, 14, 0, 2, 3, 5, 1, 3, 6, 12, 10, 15);
    dev_data = '0;
    repeat (2) @(negedge clk);
    chk("R1 strobes", 32'({cs_n, adv_n, oe_n}), 32'b111);
    chk("R1 bus/dir", 32'({bus_oe, dir}), 32'b00);
    chk("R1 flags", 32'({busy, done, cfg_err}), 32'b000);
    chk("R1 rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_read(32'hA1B2_C3D4, 16'h5A5A, 1'b0);
    set_cfg(0, 4, 0, 1, 2, 3, 0, 1, 2, 4, 2, 4);
    run_read(32'h1234_8765, 16'hC0DE, 1'b0);
    set_cfg(1, 31, 6, 7, 8, 15, 6, 7, 15, 31, 30, 31);
    run_read(32'hFFFF_0001, 16'h7E57, 1'b0);
    set_cfg(0, 14, 0, 2, 3, 5, 1, 3, 6, 12, 10, 15);
    run_read(32'h0F0F_F0F0, 16'h1357, 1'b1);
    set_cfg(0, 14, 2, 2, 3, 5, 1, 3, 6, 12, 10, 15);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 cfg_err set", 32'(cfg_err), 32'd1);
    chk("R9 not started", 32'(busy), 32'd0);
    chk("R9 cs idle", 32'(cs_n), 32'd1);
    repeat (5) @(negedge clk);
    chk("R9 no done", 32'(done), 32'd0);
    chk("R9 rdata kept", 32'(rdata), 32'h1357);
    set_cfg(0, 14, 0, 2, 3, 5, 1, 3, 6, 12, 13, 15);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 acc past read strobe rejected", 32'(cfg_err), 32'd1);
    set_cfg(0, 14, 0, 2, 3, 5, 1, 3, 6, 12, 10, 15);
    run_read(32'h2468_ACE0, 16'hBEEF, 1'b0);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    fork
      main();
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule